// File: doc/BRIEF.md
# Triple-Redundant Voted Up-Counter

This block is a binary up-counter held in three identical register copies. Three independent bitwise majority voters read all three copies. Each copy computes its next value from the output of its own voter, not from its own register. A copy whose contents have been corrupted therefore takes the agreed value again at the next clock edge, with no reset. As long as no more than one copy is wrong at a time, the voted count is unaffected.

Each voter drives its own output port, so a final voter outside the block can mask a failure in any one voter. A per-copy flag shows when that copy disagrees with its voter. For test, a set of per-copy strobes overwrites the chosen copies with an arbitrary value for a single edge. These are plain control pins: the block has no streaming data path, so it has no valid/ready handshake and never applies back-pressure.

Top module: `tmr_vote_counter`

## Requirements
- R1: While `rst_ni` is low, all three copies are cleared asynchronously. All three count outputs read 0 and `mismatch_o` reads 3'b000.
- R2: With `en_i` high and no injection, each clock edge raises every count output by one, modulo 2^WIDTH. The value 2^WIDTH-1 is followed by 0.
- R3: With `en_i` low and no injection, every count output holds its value across the edge.
- R4: Whenever at most one copy differs from the others, `cnt_a_o`, `cnt_b_o` and `cnt_c_o` are identical.
- R5: If exactly one bit of `inj_en_i` is high at an edge, the count outputs after that edge equal the uncorrupted result: the previous count plus `en_i`.
- R6: Bit k of `mismatch_o` is high in exactly those cycles where copy k differs from the voted value. Bit 0 is copy A, bit 1 is copy B and bit 2 is copy C. This also applies to `inj_en_i`, where bit k overwrites copy k with `inj_val_i`.
- R7: After any edge at which `inj_en_i` is 3'b000, all three copies are equal, so `mismatch_o` is 3'b000.
- R8: An injection takes effect whether `en_i` is high or low. With `en_i` low, the corrupted copy realigns to the held count.
- R9: Each voter output bit is the majority of the three copies' bits at that position. If two copies are overwritten at once, the outputs are therefore the bitwise majority of the two injected values and the third copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Count enable, shared by all copies |
| inj_en_i | input | 3 | Per-copy overwrite strobe (bit0=A, bit1=B, bit2=C) |
| inj_val_i | input | WIDTH | Value loaded into the strobed copies |
| cnt_a_o | output | WIDTH | Count from voter A |
| cnt_b_o | output | WIDTH | Count from voter B |
| cnt_c_o | output | WIDTH | Count from voter C |
| mismatch_o | output | 3 | Copy k differs from its voted value |

## Verification
The hard case to reach is a copy that is wrong for exactly one cycle and then silently realigns. Normal counting never produces such a state. The bench produces it by using the injection strobes to overwrite one copy with a value chosen to differ from the running count. It then checks the voted outputs and the single-cycle mismatch pulse on the following cycle, and the cleared flags on the cycle after that. The same is done with the enable low, at the wrap point, and with two copies overwritten at once. The double-overwrite case shows the bitwise majority directly and shows that the copies recover.

// File: rtl/tmr_cnt_pkg.sv
package tmr_cnt_pkg;
  // Number of redundant copies and voters; the voting scheme requires three.
  localparam int unsigned COPIES = 3;
endpackage

// File: rtl/maj3_voter.sv
module maj3_voter #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  output logic [W-1:0] y_o
);
  // Each output bit follows at least two of the three inputs.
  always_comb y_o = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
endmodule

// File: rtl/tmr_cnt_copy.sv
module tmr_cnt_copy #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         inj_i,
  input  logic [W-1:0] inj_val_i,
  input  logic [W-1:0] voted_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] nxt;

  // Next state is built from the voted value, never from q_o.
  always_comb begin
    if (inj_i)     nxt = inj_val_i;
    else if (en_i) nxt = voted_i + 1'b1;
    else           nxt = voted_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= nxt;
  end
endmodule

// File: rtl/tmr_vote_counter.sv
module tmr_vote_counter #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [2:0]       inj_en_i,
  input  logic [WIDTH-1:0] inj_val_i,
  output logic [WIDTH-1:0] cnt_a_o,
  output logic [WIDTH-1:0] cnt_b_o,
  output logic [WIDTH-1:0] cnt_c_o,
  output logic [2:0]       mismatch_o
);
  import tmr_cnt_pkg::*;

  logic [WIDTH-1:0] copy_q [COPIES];
  logic [WIDTH-1:0] vote   [COPIES];

  for (genvar k = 0; k < COPIES; k++) begin : g_lane
    // One voter per lane: all copies in, one voted word out.
    maj3_voter #(.W(WIDTH)) u_vote (
      .a_i (copy_q[0]),
      .b_i (copy_q[1]),
      .c_i (copy_q[2]),
      .y_o (vote[k])
    );

    // The copy of this lane is fed back from this lane's voter.
    tmr_cnt_copy #(.W(WIDTH)) u_copy (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (en_i),
      .inj_i     (inj_en_i[k]),
      .inj_val_i (inj_val_i),
      .voted_i   (vote[k]),
      .q_o       (copy_q[k])
    );

    assign mismatch_o[k] = (copy_q[k] != vote[k]);
  end

  assign cnt_a_o = vote[0];
  assign cnt_b_o = vote[1];
  assign cnt_c_o = vote[2];
endmodule

// File: rtl/tmr_vote_counter_chk.sv
module tmr_vote_counter_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic [2:0]       inj_en_i,
  input logic [WIDTH-1:0] cnt_a_o,
  input logic [WIDTH-1:0] cnt_b_o,
  input logic [WIDTH-1:0] cnt_c_o,
  input logic [2:0]       mismatch_o
);
  logic [WIDTH-1:0] after_step;
  logic [WIDTH-1:0] after_en;

  assign after_step = cnt_a_o + 1'b1;
  assign after_en   = en_i ? after_step : cnt_a_o;

  AST_VOTERS_AGREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(mismatch_o) <= 1) |-> (cnt_a_o == cnt_b_o && cnt_b_o == cnt_c_o)); // R4

  AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && inj_en_i == 3'b000) |=> (cnt_a_o == $past(after_step))); // R2

  AST_COUNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && inj_en_i == 3'b000) |=> $stable(cnt_a_o)); // R3

  AST_SINGLE_UPSET_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(inj_en_i) == 1) |=> (cnt_a_o == $past(after_en))); // R5

  AST_RESYNC_NEXT_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inj_en_i == 3'b000) |=> (mismatch_o == 3'b000)); // R7
endmodule

bind tmr_vote_counter tmr_vote_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .inj_en_i   (inj_en_i),
  .cnt_a_o    (cnt_a_o),
  .cnt_b_o    (cnt_b_o),
  .cnt_c_o    (cnt_c_o),
  .mismatch_o (mismatch_o)
);

// File: tb/tmr_vote_counter_tb.sv
module tmr_vote_counter_tb;
  localparam int unsigned W    = 8;
  localparam int unsigned MASK = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         en_i = 1'b0;
  logic [2:0]   inj_en_i = 3'b000;
  logic [W-1:0] inj_val_i = '0;
  logic [W-1:0] cnt_a_o, cnt_b_o, cnt_c_o;
  logic [2:0]   mismatch_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int unsigned mdl [3];

  always #4 clk = ~clk;

  tmr_vote_counter #(.WIDTH(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .inj_en_i(inj_en_i),
    .inj_val_i(inj_val_i), .cnt_a_o(cnt_a_o), .cnt_b_o(cnt_b_o),
    .cnt_c_o(cnt_c_o), .mismatch_o(mismatch_o)
  );

  // Majority per bit by counting ones at each position.
  function automatic int unsigned vote3(int unsigned x, int unsigned y, int unsigned z);
    int unsigned r = 0;
    for (int b = 0; b < W; b++) begin
      int n = int'(x[b]) + int'(y[b]) + int'(z[b]);
      if (n >= 2) r |= (1 << b);
    end
    return r;
  endfunction

  task automatic chk(bit ok, string tag, string what, int unsigned act, int unsigned exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    int unsigned v = vote3(mdl[0], mdl[1], mdl[2]);
    logic [2:0] mm;
    for (int k = 0; k < 3; k++) mm[k] = (mdl[k] != v);
    chk(cnt_a_o == v[W-1:0], tag, "cnt_a", cnt_a_o, v);
    chk(cnt_b_o == v[W-1:0], tag, "cnt_b", cnt_b_o, v);
    chk(cnt_c_o == v[W-1:0], tag, "cnt_c", cnt_c_o, v);
    chk(mismatch_o == mm, tag, "mismatch", mismatch_o, mm);
  endtask

  // Drive at the falling edge, let one rising edge pass, compare at the next falling edge.
  task automatic step(bit en, bit [2:0] inj, int unsigned val, string tag);
    int unsigned v;
    en_i = en; inj_en_i = inj; inj_val_i = val[W-1:0];
    @(posedge clk);
    v = vote3(mdl[0], mdl[1], mdl[2]);
    for (int k = 0; k < 3; k++)
      mdl[k] = inj[k] ? (val & MASK) : ((v + int'(en)) & MASK);
    @(negedge clk);
    inj_en_i = 3'b000;
    compare(tag);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    for (int k = 0; k < 3; k++) mdl[k] = 0;
    @(negedge clk);
    @(negedge clk);
    compare("R1");
    rst_ni = 1'b1;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R2: plain counting
    for (int i = 0; i < 20; i++) step(1'b1, 3'b000, 0, "R2");
    // R3: hold
    for (int i = 0; i < 5; i++) step(1'b0, 3'b000, 0, "R3");
    // R5 / R6 / R7: single upset in each copy, with enable high
    for (int k = 0; k < 3; k++) begin
      step(1'b1, 3'b001 << k, 8'hA5 ^ k, "R5_R6");
      step(1'b1, 3'b000, 0, "R7");
    end
    // R8: upset with the enable low, realign to the held value
    step(1'b0, 3'b010, 8'h3C, "R8");
    step(1'b0, 3'b000, 0, "R8");
    step(1'b0, 3'b100, 8'hFF, "R8");
    step(1'b1, 3'b000, 0, "R8");
    // R6: an injected value equal to the correct count raises no flag
    begin
      int unsigned cur = vote3(mdl[0], mdl[1], mdl[2]);
      step(1'b1, 3'b001, (cur + 1) & MASK, "R6");
    end
    // R9: two copies overwritten at once, then recovery
    step(1'b1, 3'b011, 8'hF0, "R9");
    step(1'b1, 3'b000, 0, "R9");
    for (int k = 0; k < 3; k++) mdl[k] = mdl[k];
    en_i = 1'b1; inj_en_i = 3'b101; inj_val_i = 8'h0F;
    step(1'b1, 3'b101, 8'h0F, "R9");
    step(1'b0, 3'b011, 8'h55, "R9");
    step(1'b0, 3'b000, 0, "R9");
    // R2: run up to and across the wrap point, upsetting near it
    for (int i = 0; i < 300; i++) begin
      int unsigned cur = vote3(mdl[0], mdl[1], mdl[2]);
      if (cur == MASK - 1) step(1'b1, 3'b100, 8'h00, "R5_wrap");
      else                 step(1'b1, 3'b000, 0, "R2_wrap");
    end
    // R4: outputs agree over a mixed run
    for (int i = 0; i < 30; i++)
      step(i[0], (i % 4 == 0) ? (3'b001 << (i % 3)) : 3'b000, i * 37, "R4");
    // R1: reset in mid-count
    do_reset();
    step(1'b1, 3'b000, 0, "R1");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule